// File: doc/BRIEF.md
# Audio Processor Control Register Slave

This block is the write-only serial control port of a television audio routing and gain processor. It watches an I2C bus (SCL and SDA), accepts writes for its own device address, and holds ten control registers. The register contents leave the block as parallel fields: loudspeaker master volume, left and right balance trim, bass, treble, left and right headphone volume, a source select and mute bit for each of the three outputs, three effect-mode bits and two general-purpose port levels.

A transfer has a fixed shape. The master sends a start, the device address with the write bit, one subaddress byte, then one or more data bytes, and ends with a stop. The first data byte lands in the register named by the subaddress, and each further byte goes to the next register up. A strap input chooses between two device addresses, so two of these blocks can share one bus. Both bus lines pass through a synchroniser and a glitch filter. All logic runs on the system clock, and the block only ever pulls SDA low.

Top module: `aud_ctl_i2c_slave`

## Requirements
- R1: The device answers the address byte 0x80 when `addr_sel` is 0 and 0x82 when it is 1. Bit 1 of the address follows `addr_sel` and bit 0, the read/write flag, is 0. The slave acknowledges a matching address by pulling SDA low during the ninth clock.
- R2: An address byte that does not match, or that has bit 0 set, gets no acknowledge. No register changes until the next start condition.
- R3: After a matched address, the slave acknowledges the subaddress byte and every data byte. The first data byte is written to the register at the subaddress.
- R4: Each further data byte in the same transfer goes to the subaddress one above the previous byte.
- R5: Data bytes aimed at subaddress 0x0A or above are acknowledged and discarded. The pointer never wraps back to 0x00.
- R6: Only defined bits are stored and all other bits hold 0. The stored masks are 0x3F at 0x00, 0x05 and 0x06; 0x1F at 0x01 to 0x03; 0x0F at 0x04; 0x4F at 0x07; 0x7F at 0x08; and 0xFF at 0x09.
- R7: After reset, registers 0x07, 0x08 and 0x09 hold 0x40, so all three mutes are active. Every other register holds 0.
- R8: `port1_pull` is asserted (pin driven low) when bit 5 of register 0x08 is 0. `port2_pull` does the same for bit 4. Each pin is released when its bit is 1.
- R9: SDA is asserted or released only while the filtered SCL is low.
- R10: A stop condition or a repeated start ends the transfer at once. A byte that was only partly shifted in has no effect.
- R11: In registers 0x07 to 0x09, bits 3:0 are the output's source select and bit 6 is its mute (1 means muted). Register 0x09 carries `fx_wide` in bit 7, `fx_effect` in bit 5 and `fx_stereo` in bit 4.
- R12: A pulse on SCL or SDA that lasts fewer than `GLITCH_CYC` system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 1 | Strap that selects address bit 1 |
| spk_vol | output | 6 | Loudspeaker master volume |
| bal_l | output | 5 | Loudspeaker left trim |
| bal_r | output | 5 | Loudspeaker right trim |
| bass | output | 5 | Bass setting |
| treble | output | 4 | Treble setting |
| hp_vol_l | output | 6 | Headphone left volume |
| hp_vol_r | output | 6 | Headphone right volume |
| hp_src | output | 4 | Headphone source select |
| hp_mute | output | 1 | Headphone mute |
| scart_src | output | 4 | Peri-TV output source select |
| scart_mute | output | 1 | Peri-TV output mute |
| spk_src | output | 4 | Loudspeaker source select |
| spk_mute | output | 1 | Loudspeaker mute |
| fx_wide | output | 1 | Effect bit: strong spatial |
| fx_effect | output | 1 | Effect bit: spatial or pseudo stereo |
| fx_stereo | output | 1 | Effect bit: stereo versus forced mono |
| port1_pull | output | 1 | Port 1 open-drain pull-down enable |
| port2_pull | output | 1 | Port 2 open-drain pull-down enable |

## Verification
The bench writes every start subaddress from 0x00 to 0x0B and runs full ten-byte bursts with several patterns. A pointer that wrapped, or that stored past 0x09, would corrupt the low registers, and a missing mask would leave bits set where 0 is expected. It sends wrong and read-flagged addresses under both strap settings: a slave that answered these would acknowledge them and take the data. It also breaks off transfers mid-byte with a stop and with a repeated start. A slave that committed partial bytes, or that kept the old pointer across the restart, would store values that were never written. Finally it injects short SCL pulses and watches every change of SDA drive. An unfiltered input would shift in an extra bit, and a badly timed drive would change SDA while SCL is high.

// File: rtl/aud_ctl_pkg.sv
package aud_ctl_pkg;
  localparam int          NREG     = 10;
  localparam int          AW       = $clog2(NREG);
  localparam logic [7:0]  DEV_BASE = 8'h80;
  localparam int          IDX_HP   = 7;
  localparam int          IDX_SC   = 8;
  localparam int          IDX_SPK  = 9;
  localparam int          MUTE_BIT = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_ACK, PH_SKIP} phase_t;
  typedef enum logic [1:0] {RL_ADDR, RL_SUB, RL_DATA}        role_t;

  // bits that exist in each register; the rest are stored as 0
  function automatic logic [7:0] live_bits(int idx);
    case (idx)
      0, 5, 6: live_bits = 8'h3F;
      1, 2, 3: live_bits = 8'h1F;
      4:       live_bits = 8'h0F;
      7:       live_bits = 8'h4F;
      8:       live_bits = 8'h7F;
      9:       live_bits = 8'hFF;
      default: live_bits = 8'h00;
    endcase
  endfunction

  // value after reset: every output muted
  function automatic logic [7:0] power_on(int idx);
    power_on = (idx >= IDX_HP && idx <= IDX_SPK) ? 8'h40 : 8'h00;
  endfunction
endpackage

// File: rtl/aud_ctl_line_filter.sv
module aud_ctl_line_filter #(
  parameter int STAGES = 2,
  parameter int HOLD   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [STAGES-1:0] sync_q;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              lvl_q, lvl_n;

  for (genvar s = 0; s < STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[s] <= 1'b1;
        else        sync_q[s] <= line_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[s] <= 1'b1;
        else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_comb begin
    cnt_n = cnt_q;
    lvl_n = lvl_q;
    if (sync_q[STAGES-1] == lvl_q) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(HOLD - 1)) begin
      lvl_n = sync_q[STAGES-1];
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      lvl_q <= lvl_n;
    end

  assign line_o = lvl_q;
endmodule

// File: rtl/aud_ctl_i2c_engine.sv
module aud_ctl_i2c_engine
  import aud_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic          addr_sel,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  phase_t     ph_q, ph_n;
  role_t      role_q, role_n;
  logic [3:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n;
  logic [7:0] ptr_q, ptr_n;
  logic       oe_q, oe_n;
  logic       scl_d, sda_d;

  logic scl_rise, scl_fall, bus_start, bus_stop, byte_done, addr_hit, ptr_live;

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign bus_start = scl_f & scl_d & sda_d & ~sda_f;
  assign bus_stop  = scl_f & scl_d & ~sda_d & sda_f;
  assign byte_done = (ph_q == PH_RX) && scl_fall && (bit_q == 4'd8);
  assign addr_hit  = (sh_q == {DEV_BASE[7:2], addr_sel, 1'b0});
  assign ptr_live  = (ptr_q < 8'(NREG));

  always_comb begin
    ph_n   = ph_q;
    role_n = role_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    ptr_n  = ptr_q;
    oe_n   = oe_q;
    if (bus_start) begin
      ph_n   = PH_RX;
      role_n = RL_ADDR;
      bit_n  = '0;
      oe_n   = 1'b0;
    end else if (bus_stop) begin
      ph_n = PH_IDLE;
      oe_n = 1'b0;
    end else begin
      case (ph_q)
        PH_RX: begin
          if (scl_rise && bit_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_f};
            bit_n = bit_q + 1'b1;
          end else if (byte_done) begin
            ph_n = PH_ACK;
            oe_n = 1'b1;
            case (role_q)
              RL_ADDR: if (!addr_hit) begin
                ph_n = PH_SKIP;
                oe_n = 1'b0;
              end
              RL_SUB:  ptr_n = sh_q;
              default: if (ptr_q != 8'hFF) ptr_n = ptr_q + 1'b1;
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            oe_n   = 1'b0;
            ph_n   = PH_RX;
            bit_n  = '0;
            role_n = (role_q == RL_ADDR) ? RL_SUB : RL_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      role_q <= RL_ADDR;
      bit_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      ph_q   <= ph_n;
      role_q <= role_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      ptr_q  <= ptr_n;
      oe_q   <= oe_n;
      scl_d  <= scl_f;
      sda_d  <= sda_f;
    end

  assign sda_oe  = oe_q;
  assign wr_en   = byte_done && (role_q == RL_DATA) && ptr_live;
  assign wr_addr = ptr_q[AW-1:0];
  assign wr_data = sh_q;
endmodule

// File: rtl/aud_ctl_regfile.sv
module aud_ctl_regfile
  import aud_ctl_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [7:0]                wr_data,
  output logic [NREG-1:0][7:0]      regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] KEEP = live_bits(i);
    localparam logic [7:0] INIT = power_on(i);
    logic       hit;
    logic [7:0] q, d;
    assign hit = wr_en && (wr_addr == AW'(i));
    assign d   = wr_data & KEEP;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   q <= INIT;
      else if (hit) q <= d;
    assign regs_o[i] = q;
  end
endmodule

// File: rtl/aud_ctl_i2c_slave.sv
module aud_ctl_i2c_slave
  import aud_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_sel,
  output logic [5:0] spk_vol,
  output logic [4:0] bal_l,
  output logic [4:0] bal_r,
  output logic [4:0] bass,
  output logic [3:0] treble,
  output logic [5:0] hp_vol_l,
  output logic [5:0] hp_vol_r,
  output logic [3:0] hp_src,
  output logic       hp_mute,
  output logic [3:0] scart_src,
  output logic       scart_mute,
  output logic [3:0] spk_src,
  output logic       spk_mute,
  output logic       fx_wide,
  output logic       fx_effect,
  output logic       fx_stereo,
  output logic       port1_pull,
  output logic       port2_pull
);
  logic [1:0]            rst_pipe;
  logic                  rst_s;
  logic                  scl_f, sda_f;
  logic                  wr_en;
  logic [AW-1:0]         wr_addr;
  logic [7:0]            wr_data;
  logic [NREG-1:0][7:0]  reg_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  assign rst_s = rst_pipe[1];

  aud_ctl_line_filter #(.STAGES(SYNC_STAGES), .HOLD(GLITCH_CYC)) u_scl_flt (
    .clk(clk), .rst_n(rst_s), .line_i(scl_i), .line_o(scl_f));
  aud_ctl_line_filter #(.STAGES(SYNC_STAGES), .HOLD(GLITCH_CYC)) u_sda_flt (
    .clk(clk), .rst_n(rst_s), .line_i(sda_i), .line_o(sda_f));

  aud_ctl_i2c_engine u_eng (
    .clk(clk), .rst_n(rst_s), .scl_f(scl_f), .sda_f(sda_f), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  aud_ctl_regfile u_rf (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_o(reg_q));

  assign spk_vol    = reg_q[0][5:0];
  assign bal_l      = reg_q[1][4:0];
  assign bal_r      = reg_q[2][4:0];
  assign bass       = reg_q[3][4:0];
  assign treble     = reg_q[4][3:0];
  assign hp_vol_l   = reg_q[5][5:0];
  assign hp_vol_r   = reg_q[6][5:0];
  assign hp_src     = reg_q[IDX_HP][3:0];
  assign hp_mute    = reg_q[IDX_HP][MUTE_BIT];
  assign scart_src  = reg_q[IDX_SC][3:0];
  assign scart_mute = reg_q[IDX_SC][MUTE_BIT];
  assign port1_pull = ~reg_q[IDX_SC][5];
  assign port2_pull = ~reg_q[IDX_SC][4];
  assign spk_src    = reg_q[IDX_SPK][3:0];
  assign spk_mute   = reg_q[IDX_SPK][MUTE_BIT];
  assign fx_wide    = reg_q[IDX_SPK][7];
  assign fx_effect  = reg_q[IDX_SPK][5];
  assign fx_stereo  = reg_q[IDX_SPK][4];
endmodule

// File: rtl/aud_ctl_chk.sv
module aud_ctl_chk
  import aud_ctl_pkg::*;
(
  input logic                 clk,
  input logic                 rst_s,
  input logic                 scl_f,
  input logic                 sda_f,
  input logic                 sda_oe,
  input logic                 wr_en,
  input logic [AW-1:0]        wr_addr,
  input logic [NREG-1:0][7:0] reg_q
);
  // R9: drive starts only while the filtered clock is low
  a_r9_drive_on_low: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(sda_oe) |-> !scl_f);

  // R9: drive ends only while the filtered clock is low
  a_r9_release_on_low: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(sda_oe) |-> !scl_f);

  // R5: no store lands outside the ten registers
  a_r5_store_in_range: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |-> (wr_addr < AW'(NREG)));

  // R3: registers only move on a store
  a_r3_hold_without_store: assert property (@(posedge clk) disable iff (!rst_s)
    !wr_en |=> $stable(reg_q));

  // R10: a stop on the bus leaves SDA released
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_s)
    (scl_f && $past(scl_f) && !$past(sda_f) && sda_f) |=> !sda_oe);
endmodule

bind aud_ctl_i2c_slave aud_ctl_chk u_chk (
  .clk(clk), .rst_s(rst_s), .scl_f(scl_f), .sda_f(sda_f), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .reg_q(reg_q));

// File: tb/tb_aud_ctl_i2c_slave.sv
module tb_aud_ctl_i2c_slave;
  localparam int H = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl_m, sda_m, addr_sel, sda_line, sda_oe;
  logic [5:0] spk_vol, hp_vol_l, hp_vol_r;
  logic [4:0] bal_l, bal_r, bass;
  logic [3:0] treble, hp_src, scart_src, spk_src;
  logic hp_mute, scart_mute, spk_mute, fx_wide, fx_effect, fx_stereo, port1_pull, port2_pull;

  assign sda_line = sda_m & ~sda_oe;

  aud_ctl_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .spk_vol(spk_vol), .bal_l(bal_l), .bal_r(bal_r), .bass(bass),
    .treble(treble), .hp_vol_l(hp_vol_l), .hp_vol_r(hp_vol_r), .hp_src(hp_src),
    .hp_mute(hp_mute), .scart_src(scart_src), .scart_mute(scart_mute), .spk_src(spk_src),
    .spk_mute(spk_mute), .fx_wide(fx_wide), .fx_effect(fx_effect), .fx_stereo(fx_stereo),
    .port1_pull(port1_pull), .port2_pull(port2_pull));

  int errs = 0, checks = 0, cyc = 0, viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] expv [10];
  logic [7:0] buf_b [16];
  logic [15:0] acks;

  // R6 masks and R7 reset values, as stated in the requirements
  function automatic logic [7:0] keep(int a);
    if (a == 0 || a == 5 || a == 6) return 8'h3F;
    if (a >= 1 && a <= 3) return 8'h1F;
    if (a == 4) return 8'h0F;
    if (a == 7) return 8'h4F;
    if (a == 8) return 8'h7F;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] seen(int a);
    case (a)
      0: return {2'b0, spk_vol};
      1: return {3'b0, bal_l};
      2: return {3'b0, bal_r};
      3: return {3'b0, bass};
      4: return {4'b0, treble};
      5: return {2'b0, hp_vol_l};
      6: return {2'b0, hp_vol_r};
      7: return {1'b0, hp_mute, 2'b0, hp_src};
      8: return {1'b0, scart_mute, ~port1_pull, ~port2_pull, scart_src};
      default: return {fx_wide, spk_mute, fx_effect, fx_stereo, spk_src};
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 10; a++) check($sformatf("%s reg%0d", tag, a), seen(a), expv[a]);
  endtask

  task automatic wait_c(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(logic b, logic glitch);
    wait_c(H/2); sda_m = b;
    if (glitch) begin scl_m = 1'b1; wait_c(2); scl_m = 1'b0; end
    wait_c(H/2); scl_m = 1'b1; wait_c(H); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    wait_c(1); sda_m = 1'b1; wait_c(H); scl_m = 1'b1; wait_c(H);
    sda_m = 1'b0; wait_c(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_c(H/2); sda_m = 1'b0; wait_c(H/2); scl_m = 1'b1; wait_c(H); sda_m = 1'b1; wait_c(H);
  endtask

  task automatic put_byte(logic [7:0] b, int gbit, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i], (7 - i) == gbit);
    wait_c(H/2); sda_m = 1'b1; wait_c(H/2); scl_m = 1'b1;
    wait_c(H/2); ack = ~sda_line; wait_c(H/2); scl_m = 1'b0;
  endtask

  // full transfer; take=1 means the model expects it to be accepted
  task automatic do_write(logic [7:0] dev, logic [7:0] sub, int n, bit take, int gbit);
    logic a;
    acks = '0;
    bus_start();
    put_byte(dev, -1, a); acks[0] = a;
    put_byte(sub, -1, a); acks[1] = a;
    for (int j = 0; j < n; j++) begin put_byte(buf_b[j], (j == 0) ? gbit : -1, a); acks[2+j] = a; end
    bus_stop();
    wait_c(8);
    if (take)
      for (int j = 0; j < n; j++)
        if (int'(sub) + j < 10) expv[int'(sub) + j] = buf_b[j] & keep(int'(sub) + j);
  endtask

  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_m) viol++;
    oe_prev = sda_oe;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errs++; checks++;
      $display("FAIL watchdog R3 got=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    logic a;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; addr_sel = 1'b0;
    for (int i = 0; i < 10; i++) expv[i] = (i >= 7) ? 8'h40 : 8'h00;
    wait_c(10); rst_n = 1'b1; wait_c(10);

    // R7 reset state, R8 both ports pulled low after reset
    check_all("R7 reset");
    check("R8 port1 pulled at reset", port1_pull, 1);
    check("R8 port2 pulled at reset", port2_pull, 1);

    // R3 R4 R6: full bursts from subaddress 0 with several patterns
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 10; j++) buf_b[j] = 8'((k * 53 + j * 29) ^ 8'hC3 ^ (k * 8'h11));
      do_write(8'h80, 8'h00, 10, 1, -1);
      check($sformatf("R3 acks burst %0d", k), acks[11:0], 12'hFFF);
      check_all($sformatf("R4 R6 burst %0d", k));
    end

    // R4 R5: two-byte writes from every start point, including past the end
    for (int s = 0; s < 12; s++) begin
      buf_b[0] = 8'(s * 17 + 5); buf_b[1] = 8'(~(s * 9));
      do_write(8'h80, 8'(s), 2, 1, -1);
      check($sformatf("R5 acks start %0d", s), acks[3:0], 4'hF);
      check_all($sformatf("R4 R5 start %0d", s));
    end

    // R5: run past 0x09, pointer must not wrap to 0x00
    for (int j = 0; j < 6; j++) buf_b[j] = 8'hE0 + 8'(j);
    do_write(8'h80, 8'h08, 6, 1, -1);
    check("R5 acks overrun", acks[7:0], 8'hFF);
    check_all("R5 overrun");

    // R1 R2: address matching under both strap settings
    buf_b[0] = 8'h2A;
    do_write(8'h82, 8'h00, 1, 0, -1);
    check("R2 wrong address nack", acks[0], 0);
    check_all("R2 wrong address");
    addr_sel = 1'b1;
    buf_b[0] = 8'h15;
    do_write(8'h82, 8'h01, 1, 1, -1);
    check("R1 strap address ack", acks[2:0], 3'h7);
    check_all("R1 strap address");
    do_write(8'h80, 8'h01, 1, 0, -1);
    check("R2 base address with strap high nack", acks[0], 0);
    check_all("R2 strap high");
    addr_sel = 1'b0;
    do_write(8'h81, 8'h01, 1, 0, -1);
    check("R2 read flag nack", acks[0], 0);
    check_all("R2 read flag");

    // R10: stop in the middle of a data byte
    bus_start(); put_byte(8'h80, -1, a); put_byte(8'h03, -1, a);
    for (int i = 0; i < 5; i++) put_bit(1'b0, 1'b0);
    bus_stop(); wait_c(8);
    check_all("R10 partial then stop");

    // R10: repeated start mid-byte, then a new subaddress
    bus_start(); put_byte(8'h80, -1, a); put_byte(8'h01, -1, a);
    put_byte(8'h0B, -1, a); expv[1] = 8'h0B;
    for (int i = 0; i < 3; i++) put_bit(1'b1, 1'b0);
    bus_start(); put_byte(8'h80, -1, a); put_byte(8'h02, -1, a);
    put_byte(8'hEC, -1, a); expv[2] = 8'h0C;
    bus_stop(); wait_c(8);
    check_all("R10 repeated start");

    // R12: short SCL pulse inside a data byte must not shift a bit
    buf_b[0] = 8'h09;
    do_write(8'h80, 8'h04, 1, 1, 3);
    check("R12 acks with glitch", acks[2:0], 3'h7);
    check_all("R12 glitch");

    // R8: each port follows its own bit of register 0x08
    buf_b[0] = 8'h23;
    do_write(8'h80, 8'h08, 1, 1, -1);
    check("R8 port1 released", port1_pull, 0);
    check("R8 port2 pulled", port2_pull, 1);
    check("R11 scart unmuted src", {scart_mute, scart_src}, 5'h03);
    buf_b[0] = 8'h5A;
    do_write(8'h80, 8'h08, 1, 1, -1);
    check("R8 port1 pulled", port1_pull, 1);
    check("R8 port2 released", port2_pull, 0);
    check("R11 scart muted src", {scart_mute, scart_src}, 5'h1A);

    // R11: effect bits and loudspeaker fields
    buf_b[0] = 8'h40 | 8'h0C; buf_b[1] = 8'hB5;
    do_write(8'h80, 8'h07, 1, 1, -1);
    do_write(8'h80, 8'h09, 1, 1, -1);
    buf_b[0] = 8'hB5;
    do_write(8'h80, 8'h09, 1, 1, -1);
    check("R11 hp mute and src", {hp_mute, hp_src}, 5'h1C);
    check("R11 effect bits", {fx_wide, fx_effect, fx_stereo}, 3'b111);
    check("R11 spk mute and src", {spk_mute, spk_src}, 5'h05);
    buf_b[0] = 8'h62;
    do_write(8'h80, 8'h09, 1, 1, -1);
    check("R11 effect bits second", {fx_wide, fx_effect, fx_stereo}, 3'b010);
    check("R11 spk mute second", {spk_mute, spk_src}, 5'h12);
    check_all("R11 final");

    // R9: SDA drive never changed while SCL was high
    check("R9 drive changes during SCL high", viol, 0);

    finish_run();
  end
endmodule